// File: doc/BRIEF.md
# Display Timing Extension Block Walker

This block parses one 128-byte display timing extension block that arrives as a stream of bytes, one byte per cycle when `in_valid` is high. It first checks the identifying tag, then captures the revision, the offset at which detailed timing records start, and the capability flags. Next it walks the collection of variable-length data blocks that lies between byte 4 and that offset. For each short descriptor it finds, it emits a one-cycle event. After the data blocks it counts the 18-byte detailed timing records until a two-byte zero sentinel appears. On the last byte it reports whether the checksum is good.

Blocks follow each other back to back: the byte after byte 127 is byte 0 of the next block. A low `in_valid` stalls the walk and has no other effect. The walk is run by one finite-state machine whose current state says how the next byte is read:

- TAG goes to REV if the tag is good, and to PAD if not.
- REV goes to OFFS.
- OFFS goes to CAPS.
- CAPS goes to PAD when the offset is zero or malformed. It goes to DTD when the offset is 4. Otherwise it goes to HDR.
- HDR goes to PAD on an overrun. A zero-length block goes to HDR or DTD. Any other block goes to BODY.
- BODY stays in BODY until the last payload byte, then goes to HDR or DTD.
- DTD goes to PAD on the sentinel.
- PAD stays in PAD.
- The byte before last always forces SUM.
- SUM goes back to TAG.

Top module: `txw_ext_walker`

## Requirements
- R1: After reset every event output, `blk_done`, `csum_ok`, `malformed`, `tag_ok` and `dtd_count` are 0.
- R2: `tag_ok` is 1 for a block whose byte 0 equals 02h. For any other tag value, that block gives no events, `dtd_count` 0, and revision, offset and capability outputs of 0.
- R3: `revision` takes byte 1 and `dtd_start` takes byte 2. Byte 3 sets the capability flags: bit 7 is underscan, bit 6 basic audio, bit 5 YCbCr 4:4:4, bit 4 YCbCr 4:2:2, and bits 3:0 the native format count. These outputs hold until byte 0 of the next block.
- R4: Data blocks sit back to back from byte 4 up to the offset. Each header byte carries the type in bits 7:5 and the payload length in bits 4:0. The type codes are 1 audio, 2 video, 3 vendor and 4 speaker. Types 0, 5, 6 and 7 are skipped with no event. At most one event fires per cycle, and events come out in byte order.
- R5: Each video payload byte raises `vid_evt` in the cycle after that byte is accepted, with `vid_native` = bit 7 and `vid_index` = bits 6:0.
- R6: Each complete 3-byte group in an audio block raises `aud_evt` after its third byte. The event carries format = first byte bits 6:3, channels = first byte bits 2:0 plus one, and rates = second byte bits 6:0. A trailing group of 1 or 2 bytes gives no event.
- R7: A vendor block with at least 3 payload bytes raises `ven_evt` after its third payload byte. `ven_id` is the first byte in bits 7:0, the second in bits 15:8 and the third in bits 23:16. Shorter vendor blocks and any further payload bytes give no event.
- R8: The first payload byte of a speaker block raises `spk_evt` with `spk_mask` equal to that byte.
- R9: An offset of 04h means no data blocks, and record counting starts at byte 4. An offset of 00h means no data blocks and no records, so the count stays 0.
- R10: `malformed` is set in three cases: the offset is 1 to 3; the offset is above 127; or a header at position p with length L has p+1+L greater than the offset. Once set, the block produces no further events and no record counting.
- R11: Starting at the offset, each complete 18-byte record adds one to `dtd_count`. Counting stops at a record whose first two bytes are both 00h. A record that does not end by byte 126 is not counted.
- R12: In the cycle after byte 127, `blk_done` is high for exactly one cycle. In that cycle `csum_ok` is 1 exactly when the 128 bytes sum to 0 modulo 256, and `dtd_count` and `malformed` are final.
- R13: A cycle with `in_valid` low produces no event and no `blk_done`, and it does not move the byte position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A byte is offered this cycle |
| in_byte | input | 8 | Stream byte |
| tag_ok | output | 1 | Byte 0 matched the extension tag |
| revision | output | 8 | Captured revision byte |
| dtd_start | output | 8 | Offset where detailed records begin |
| cap_underscan | output | 1 | Underscan capability flag |
| cap_basic_audio | output | 1 | Basic audio capability flag |
| cap_ycc444 | output | 1 | YCbCr 4:4:4 capability flag |
| cap_ycc422 | output | 1 | YCbCr 4:2:2 capability flag |
| native_count | output | 4 | Count of native formats |
| vid_evt | output | 1 | Video descriptor event |
| vid_native | output | 1 | Native flag of the video descriptor |
| vid_index | output | 7 | Format index of the video descriptor |
| aud_evt | output | 1 | Audio descriptor event |
| aud_format | output | 4 | Audio format code |
| aud_channels | output | 4 | Channel count (1 to 8) |
| aud_rates | output | 7 | Sampling-rate mask |
| spk_evt | output | 1 | Speaker mask event |
| spk_mask | output | 8 | Speaker presence mask |
| ven_evt | output | 1 | Vendor registration event |
| ven_id | output | 24 | Vendor registration number |
| blk_done | output | 1 | Pulse after byte 127 |
| csum_ok | output | 1 | Checksum of the last block was zero |
| malformed | output | 1 | Structure error seen in this block |
| dtd_count | output | CNT_W | Count of detailed timing records |

## Verification
The bench aims at several corner cases, and each one shows a distinct failure:

- **Zero-length headers.** A walker that always consumes a payload byte would misread the next header.
- **Trailing audio bytes and short vendor blocks.** An off-by-one in the group counter would emit spurious or shifted audio and vendor events.
- **Header overruns and out-of-range offsets.** A design that does not halt would keep emitting events after `malformed` rises.
- **Zero offset.** A design that ignores it would count junk bytes as records.
- **A record starting 00h 05h.** A design that looks only at the first sentinel byte would stop early.
- **A seventh record cut off by the checksum byte.** A design that counts records as they start rather than as they finish would report 7 instead of 6.
- **Stall cycles between bytes.** A design that advances its position without a valid byte would shift every field.

// File: rtl/txw_pkg.sv
package txw_pkg;

    localparam int BLOCK_BYTES = 128;
    localparam int POS_W       = $clog2(BLOCK_BYTES);
    localparam logic [7:0] TAG_CODE = 8'h02;

    localparam logic [2:0] KIND_AUDIO   = 3'd1;
    localparam logic [2:0] KIND_VIDEO   = 3'd2;
    localparam logic [2:0] KIND_VENDOR  = 3'd3;
    localparam logic [2:0] KIND_SPEAKER = 3'd4;

    typedef enum logic [3:0] {
        ST_TAG,
        ST_REV,
        ST_OFFS,
        ST_CAPS,
        ST_HDR,
        ST_BODY,
        ST_DTD,
        ST_PAD,
        ST_SUM
    } walk_state_t;

endpackage

// File: rtl/txw_checksum.sv
module txw_checksum #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid,
    input  logic         first,
    input  logic [W-1:0] din,
    output logic         sum_zero
);

    logic [W-1:0] acc;
    logic [W-1:0] base;

    assign base     = first ? '0 : acc;
    assign sum_zero = ((base + din) == '0);

    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= '0;
        else if (valid)
            acc <= base + din;
    end

endmodule

// File: rtl/txw_dtd_counter.sv
module txw_dtd_counter #(
    parameter int REC    = 18,
    parameter int CNT_W  = 4,
    parameter int MAXREC = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [7:0]       din,
    output logic             term,
    output logic [CNT_W-1:0] count
);

    localparam int RW = $clog2(REC);
    localparam logic [RW-1:0] REL_LAST = RW'(REC - 1);
    localparam logic [RW-1:0] REL_ONE  = RW'(1);

    logic [RW-1:0] rel;
    logic          lead_zero;

    assign term = adv && (rel == REL_ONE) && lead_zero && (din == 8'h00);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rel       <= '0;
            lead_zero <= 1'b0;
            count     <= '0;
        end else if (clr) begin
            rel       <= '0;
            lead_zero <= 1'b0;
            count     <= '0;
        end else if (adv && !term) begin
            if (rel == '0)
                lead_zero <= (din == 8'h00);
            if (rel == REL_LAST) begin
                rel   <= '0;
                count <= count + 1'b1;
            end else begin
                rel <= rel + 1'b1;
            end
        end
    end

    // R11
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(MAXREC));

    // R11
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clr) |=> $stable(count));

endmodule

// File: rtl/txw_ext_walker.sv
module txw_ext_walker
    import txw_pkg::*;
#(
    parameter int DTD_LEN = 18,
    parameter int CNT_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             tag_ok,
    output logic [7:0]       revision,
    output logic [7:0]       dtd_start,
    output logic             cap_underscan,
    output logic             cap_basic_audio,
    output logic             cap_ycc444,
    output logic             cap_ycc422,
    output logic [3:0]       native_count,
    output logic             vid_evt,
    output logic             vid_native,
    output logic [6:0]       vid_index,
    output logic             aud_evt,
    output logic [3:0]       aud_format,
    output logic [3:0]       aud_channels,
    output logic [6:0]       aud_rates,
    output logic             spk_evt,
    output logic [7:0]       spk_mask,
    output logic             ven_evt,
    output logic [23:0]      ven_id,
    output logic             blk_done,
    output logic             csum_ok,
    output logic             malformed,
    output logic [CNT_W-1:0] dtd_count
);

    localparam int MAX_REC = (BLOCK_BYTES - 5) / DTD_LEN;
    localparam logic [POS_W-1:0] POS_SUM  = POS_W'(BLOCK_BYTES - 1);
    localparam logic [POS_W-1:0] POS_PRE  = POS_W'(BLOCK_BYTES - 2);

    walk_state_t      state, state_n;
    logic [POS_W-1:0] pos;
    logic [7:0]       d_q;
    logic [2:0]       kind_q;
    logic [4:0]       rem_q;
    logic [4:0]       idx_q;
    logic [1:0]       trip_q;

    logic [7:0]       next_pos;
    logic             hdr_over;
    logic             off_bad;
    logic             dtd_term;
    logic             sum_zero;
    walk_state_t      walk_next;
    logic             any_evt;

    assign next_pos  = {1'b0, pos} + 8'd1;
    assign hdr_over  = (next_pos + {3'b000, in_byte[4:0]}) > d_q;
    assign off_bad   = ((in_byte != 8'h00) && (in_byte < 8'h04)) || in_byte[7];
    assign walk_next = (next_pos == d_q) ? ST_DTD : ST_HDR;
    assign any_evt   = vid_evt | aud_evt | spk_evt | ven_evt;
    assign dtd_start = d_q;

    txw_checksum #(.W(8)) u_sum (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (in_valid),
        .first    (state == ST_TAG),
        .din      (in_byte),
        .sum_zero (sum_zero)
    );

    txw_dtd_counter #(.REC(DTD_LEN), .CNT_W(CNT_W), .MAXREC(MAX_REC)) u_dtd (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (in_valid && (state == ST_TAG)),
        .adv   (in_valid && (state == ST_DTD)),
        .din   (in_byte),
        .term  (dtd_term),
        .count (dtd_count)
    );

    // next-state decode
    always_comb begin
        state_n = state;
        if (in_valid) begin
            unique case (state)
                ST_TAG:  state_n = (in_byte == TAG_CODE) ? ST_REV : ST_PAD;
                ST_REV:  state_n = ST_OFFS;
                ST_OFFS: state_n = ST_CAPS;
                ST_CAPS: state_n = ((d_q == 8'h00) || malformed) ? ST_PAD : walk_next;
                ST_HDR: begin
                    if (hdr_over)
                        state_n = ST_PAD;
                    else if (in_byte[4:0] == 5'd0)
                        state_n = walk_next;
                    else
                        state_n = ST_BODY;
                end
                ST_BODY: state_n = (rem_q == 5'd1) ? walk_next : ST_BODY;
                ST_DTD:  state_n = dtd_term ? ST_PAD : ST_DTD;
                ST_PAD:  state_n = ST_PAD;
                ST_SUM:  state_n = ST_TAG;
                default: state_n = ST_TAG;
            endcase
            if (pos == POS_PRE)
                state_n = ST_SUM;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_TAG;
        else
            state <= state_n;
    end

    // outputs and walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos             <= '0;
            d_q             <= '0;
            kind_q          <= '0;
            rem_q           <= '0;
            idx_q           <= '0;
            trip_q          <= '0;
            tag_ok          <= 1'b0;
            revision        <= '0;
            cap_underscan   <= 1'b0;
            cap_basic_audio <= 1'b0;
            cap_ycc444      <= 1'b0;
            cap_ycc422      <= 1'b0;
            native_count    <= '0;
            vid_evt         <= 1'b0;
            vid_native      <= 1'b0;
            vid_index       <= '0;
            aud_evt         <= 1'b0;
            aud_format      <= '0;
            aud_channels    <= '0;
            aud_rates       <= '0;
            spk_evt         <= 1'b0;
            spk_mask        <= '0;
            ven_evt         <= 1'b0;
            ven_id          <= '0;
            blk_done        <= 1'b0;
            csum_ok         <= 1'b0;
            malformed       <= 1'b0;
        end else begin
            vid_evt  <= 1'b0;
            aud_evt  <= 1'b0;
            spk_evt  <= 1'b0;
            ven_evt  <= 1'b0;
            blk_done <= 1'b0;
            if (in_valid) begin
                pos <= pos + 1'b1;
                unique case (state)
                    ST_TAG: begin
                        tag_ok          <= (in_byte == TAG_CODE);
                        revision        <= '0;
                        d_q             <= '0;
                        cap_underscan   <= 1'b0;
                        cap_basic_audio <= 1'b0;
                        cap_ycc444      <= 1'b0;
                        cap_ycc422      <= 1'b0;
                        native_count    <= '0;
                        malformed       <= 1'b0;
                    end
                    ST_REV:  revision <= in_byte;
                    ST_OFFS: begin
                        d_q       <= in_byte;
                        malformed <= off_bad;
                    end
                    ST_CAPS: begin
                        cap_underscan   <= in_byte[7];
                        cap_basic_audio <= in_byte[6];
                        cap_ycc444      <= in_byte[5];
                        cap_ycc422      <= in_byte[4];
                        native_count    <= in_byte[3:0];
                    end
                    ST_HDR: begin
                        kind_q <= in_byte[7:5];
                        rem_q  <= in_byte[4:0];
                        idx_q  <= '0;
                        trip_q <= '0;
                        if (hdr_over)
                            malformed <= 1'b1;
                    end
                    ST_BODY: begin
                        rem_q <= rem_q - 1'b1;
                        idx_q <= idx_q + 1'b1;
                        unique case (kind_q)
                            KIND_VIDEO: begin
                                vid_evt    <= 1'b1;
                                vid_native <= in_byte[7];
                                vid_index  <= in_byte[6:0];
                            end
                            KIND_AUDIO: begin
                                unique case (trip_q)
                                    2'd0: begin
                                        aud_format   <= in_byte[6:3];
                                        aud_channels <= {1'b0, in_byte[2:0]} + 4'd1;
                                        trip_q       <= 2'd1;
                                    end
                                    2'd1: begin
                                        aud_rates <= in_byte[6:0];
                                        trip_q    <= 2'd2;
                                    end
                                    default: begin
                                        aud_evt <= 1'b1;
                                        trip_q  <= 2'd0;
                                    end
                                endcase
                            end
                            KIND_VENDOR: begin
                                if (idx_q == 5'd0) ven_id[7:0]   <= in_byte;
                                if (idx_q == 5'd1) ven_id[15:8]  <= in_byte;
                                if (idx_q == 5'd2) begin
                                    ven_id[23:16] <= in_byte;
                                    ven_evt       <= 1'b1;
                                end
                            end
                            KIND_SPEAKER: begin
                                if (idx_q == 5'd0) begin
                                    spk_evt  <= 1'b1;
                                    spk_mask <= in_byte;
                                end
                            end
                            default: ;
                        endcase
                    end
                    ST_DTD, ST_PAD: ;
                    ST_SUM: begin
                        blk_done <= 1'b1;
                        csum_ok  <= sum_zero;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R4
    one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({vid_evt, aud_evt, spk_evt, ven_evt}));

    // R2
    event_needs_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_evt |-> tag_ok);

    // R10
    halt_on_malformed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        malformed |-> !any_evt);

    // R12
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |=> !blk_done);

    // R13
    stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!any_evt && !blk_done && $stable(pos)));

    // R12
    sum_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUM) |-> (pos == POS_SUM));

endmodule

// File: tb/txw_ext_walker_tb.sv
`timescale 1ns/100ps
module txw_ext_walker_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        tag_ok, cap_underscan, cap_basic_audio, cap_ycc444, cap_ycc422;
    logic [7:0]  revision, dtd_start, spk_mask;
    logic [3:0]  native_count, aud_format, aud_channels, dtd_count;
    logic        vid_evt, vid_native, aud_evt, spk_evt, ven_evt;
    logic [6:0]  vid_index, aud_rates;
    logic [23:0] ven_id;
    logic        blk_done, csum_ok, malformed;

    always #2.5 clk = ~clk;

    txw_ext_walker u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .tag_ok(tag_ok), .revision(revision), .dtd_start(dtd_start),
        .cap_underscan(cap_underscan), .cap_basic_audio(cap_basic_audio),
        .cap_ycc444(cap_ycc444), .cap_ycc422(cap_ycc422), .native_count(native_count),
        .vid_evt(vid_evt), .vid_native(vid_native), .vid_index(vid_index),
        .aud_evt(aud_evt), .aud_format(aud_format), .aud_channels(aud_channels),
        .aud_rates(aud_rates), .spk_evt(spk_evt), .spk_mask(spk_mask),
        .ven_evt(ven_evt), .ven_id(ven_id), .blk_done(blk_done),
        .csum_ok(csum_ok), .malformed(malformed), .dtd_count(dtd_count)
    );

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;

    logic [7:0]  blk [128];
    logic [31:0] exp_q [$];
    logic        exp_tag, exp_mal, exp_sum;
    logic [7:0]  exp_rev, exp_d, exp_caps;
    int          exp_cnt;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    task automatic clear_blk();
        for (int i = 0; i < 128; i++) blk[i] = 8'h00;
    endtask

    task automatic seal();
        logic [7:0] s;
        s = 8'h00;
        for (int i = 0; i < 127; i++) s = s + blk[i];
        blk[127] = 8'h00 - s;
    endtask

    // expectations from the requirements
    task automatic model_block();
        logic [7:0] s, h, b1, b2;
        logic [3:0] ch;
        int p, len, typ;
        exp_q.delete();
        s = 8'h00;
        for (int i = 0; i < 128; i++) s = s + blk[i];
        exp_sum = (s == 8'h00);
        exp_tag = (blk[0] == 8'h02);
        exp_mal = 1'b0;
        exp_cnt = 0;
        exp_rev = 8'h00; exp_d = 8'h00; exp_caps = 8'h00;
        if (!exp_tag) return;
        exp_rev = blk[1]; exp_d = blk[2]; exp_caps = blk[3];
        if ((exp_d != 0 && exp_d < 4) || exp_d > 127) begin exp_mal = 1'b1; return; end
        if (exp_d == 0) return;
        p = 4;
        while (p < int'(exp_d)) begin
            h = blk[p];
            len = int'(h[4:0]);
            typ = int'(h[7:5]);
            if (p + 1 + len > int'(exp_d)) begin exp_mal = 1'b1; return; end
            if (typ == 2)
                for (int i = 0; i < len; i++) exp_q.push_back({4'd1, 20'd0, blk[p+1+i]});
            if (typ == 1)
                for (int g = 0; g + 3 <= len; g += 3) begin
                    b1 = blk[p+1+g]; b2 = blk[p+2+g];
                    ch = {1'b0, b1[2:0]} + 4'd1;
                    exp_q.push_back({4'd2, 13'd0, b1[6:3], ch, b2[6:0]});
                end
            if (typ == 3 && len >= 3)
                exp_q.push_back({4'd4, 4'd0, blk[p+3], blk[p+2], blk[p+1]});
            if (typ == 4 && len >= 1)
                exp_q.push_back({4'd3, 20'd0, blk[p+1]});
            p = p + 1 + len;
        end
        p = int'(exp_d);
        while (p + 18 <= 127) begin
            if (blk[p] == 8'h00 && blk[p+1] == 8'h00) break;
            exp_cnt++;
            p += 18;
        end
    endtask

    function automatic string req_of(input logic [31:0] e);
        case (e[31:28])
            4'd1: return "R5";
            4'd2: return "R6";
            4'd3: return "R8";
            default: return "R7";
        endcase
    endfunction

    task automatic feed_block(input string ctx, input bit stalls);
        logic [31:0] act, e;
        int nev;
        model_block();
        for (int i = 0; i < 128; i++) begin
            if (stalls && ($urandom % 4 == 0)) begin
                @(negedge clk); in_valid = 1'b0;
                @(posedge clk); #1;
                check(!(vid_evt | aud_evt | spk_evt | ven_evt | blk_done), "R13",
                      {ctx, " stall output"}, {vid_evt, aud_evt, spk_evt, ven_evt, blk_done}, 0);
            end
            @(negedge clk); in_valid = 1'b1; in_byte = blk[i];
            @(posedge clk); #1;
            nev = int'(vid_evt) + int'(aud_evt) + int'(spk_evt) + int'(ven_evt);
            if (nev > 1) check(1'b0, "R4", {ctx, " several events"}, nev, 1);
            if (nev == 1) begin
                if (vid_evt) act = {4'd1, 20'd0, vid_native, vid_index};
                else if (aud_evt) act = {4'd2, 13'd0, aud_format, aud_channels, aud_rates};
                else if (spk_evt) act = {4'd3, 20'd0, spk_mask};
                else act = {4'd4, 4'd0, ven_id};
                if (exp_q.size() == 0) check(1'b0, "R4", {ctx, " unexpected event"}, act, 0);
                else begin
                    e = exp_q.pop_front();
                    check(act == e, req_of(e), {ctx, " event"}, act, e);
                end
            end
            if (i == 127) begin
                check(blk_done == 1'b1, "R12", {ctx, " done pulse"}, blk_done, 1);
                check(csum_ok == exp_sum, "R12", {ctx, " checksum"}, csum_ok, exp_sum);
                check(int'(dtd_count) == exp_cnt, "R11", {ctx, " record count"}, dtd_count, exp_cnt);
                check(malformed == exp_mal, "R10", {ctx, " malformed"}, malformed, exp_mal);
                check(tag_ok == exp_tag, "R2", {ctx, " tag"}, tag_ok, exp_tag);
                check(revision == exp_rev && dtd_start == exp_d, "R3", {ctx, " rev/offset"},
                      {revision, dtd_start}, {exp_rev, exp_d});
                check({cap_underscan, cap_basic_audio, cap_ycc444, cap_ycc422, native_count} == exp_caps,
                      "R3", {ctx, " caps"},
                      {cap_underscan, cap_basic_audio, cap_ycc444, cap_ycc422, native_count}, exp_caps);
            end
        end
        @(negedge clk); in_valid = 1'b0;
        @(posedge clk); #1;
        check(blk_done == 1'b0, "R12", {ctx, " done one cycle"}, blk_done, 0);
        check(exp_q.size() == 0, "R4", {ctx, " missing events"}, exp_q.size(), 0);
    endtask

    task automatic gen_random();
        int p, nb, len, nd, room;
        clear_blk();
        blk[0] = 8'h02;
        blk[1] = 8'($urandom);
        blk[3] = 8'($urandom);
        p = 4;
        nb = $urandom % 7;
        for (int k = 0; k < nb; k++) begin
            len = $urandom % 10;
            if (p + 1 + len > 70) break;
            blk[p] = {3'($urandom), 5'(len)};
            for (int j = 0; j < len; j++) blk[p+1+j] = 8'($urandom);
            p = p + 1 + len;
        end
        blk[2] = 8'(p);
        room = (127 - p) / 18;
        nd = $urandom % (room + 1);
        for (int r = 0; r < nd; r++) begin
            for (int j = 0; j < 18; j++) blk[p+j] = 8'($urandom);
            if (blk[p] == 8'h00) blk[p] = 8'h01;
            p += 18;
        end
        seal();
    endtask

    initial begin
        void'($urandom(32'd7741));
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        // R1 reset state
        check({tag_ok, vid_evt, aud_evt, spk_evt, ven_evt, blk_done, csum_ok, malformed} == 8'd0
              && dtd_count == 4'd0, "R1", "reset outputs",
              {tag_ok, vid_evt, aud_evt, spk_evt, ven_evt, blk_done, csum_ok, malformed, dtd_count}, 0);

        // R9 zero offset: bytes after the header are ignored
        clear_blk(); blk[0] = 8'h02; blk[1] = 8'h03; blk[2] = 8'h00; blk[3] = 8'hF3;
        blk[4] = 8'h43; blk[5] = 8'h81; blk[6] = 8'h02; blk[7] = 8'h03;
        for (int i = 8; i < 60; i++) blk[i] = 8'h11;
        seal(); feed_block("R9 zero offset", 1'b0);

        // R9 offset 4 with seven records, last cut by the checksum byte (R11)
        clear_blk(); blk[0] = 8'h02; blk[1] = 8'h03; blk[2] = 8'h04; blk[3] = 8'h52;
        for (int r = 0; r < 7; r++)
            for (int j = 0; j < 18; j++)
                if (4 + 18*r + j < 127) blk[4 + 18*r + j] = 8'(8'h10 + r + j);
        seal(); feed_block("R9 R11 full", 1'b1);

        // R10 small offset
        clear_blk(); blk[0] = 8'h02; blk[2] = 8'h02; blk[4] = 8'h42; blk[5] = 8'h05;
        seal(); feed_block("R10 offset2", 1'b0);

        // R10 large offset
        clear_blk(); blk[0] = 8'h02; blk[2] = 8'd200; blk[4] = 8'h42; blk[5] = 8'h05;
        seal(); feed_block("R10 offset200", 1'b0);

        // R10 header overrun
        clear_blk(); blk[0] = 8'h02; blk[2] = 8'd10; blk[4] = 8'h48;
        for (int i = 5; i < 40; i++) blk[i] = 8'h33;
        seal(); feed_block("R10 overrun", 1'b0);

        // R2 wrong tag
        gen_random(); blk[0] = 8'h70; seal(); feed_block("R2 bad tag", 1'b0);

        // R12 corrupt checksum
        gen_random(); blk[127] = blk[127] ^ 8'h5A; feed_block("R12 bad sum", 1'b0);

        // R4 R6 R7 R8 mixed blocks, reserved skip, 00 05 record start
        clear_blk(); blk[0] = 8'h02; blk[1] = 8'h03; blk[2] = 8'd29; blk[3] = 8'hA1;
        blk[4] = 8'h24; blk[5] = 8'h0D; blk[6] = 8'h7F; blk[7] = 8'h07; blk[8] = 8'hAA;
        blk[9] = 8'h62; blk[10] = 8'h11; blk[11] = 8'h22;
        blk[12] = 8'h83; blk[13] = 8'h4F; blk[14] = 8'h00; blk[15] = 8'h00;
        blk[16] = 8'hC3; blk[17] = 8'h01; blk[18] = 8'h02; blk[19] = 8'h03;
        blk[20] = 8'h65; blk[21] = 8'h03; blk[22] = 8'h0C; blk[23] = 8'h00; blk[24] = 8'hAA; blk[25] = 8'hBB;
        blk[26] = 8'h42; blk[27] = 8'h90; blk[28] = 8'h10;
        for (int j = 0; j < 18; j++) blk[29+j] = 8'(8'h21 + j);
        blk[47] = 8'h00; blk[48] = 8'h05;
        for (int j = 2; j < 18; j++) blk[47+j] = 8'h44;
        seal(); feed_block("R4 mixed", 1'b1);

        // R4 zero-length headers
        clear_blk(); blk[0] = 8'h02; blk[2] = 8'd7;
        blk[4] = 8'h40; blk[5] = 8'h20; blk[6] = 8'hE0;
        seal(); feed_block("R4 empty blocks", 1'b0);

        for (int n = 0; n < 40; n++) begin
            gen_random();
            feed_block("R4 random", n[0]);
        end

        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule